// File: doc/BRIEF.md
# Reservation Monitor for Load-Linked / Store-Conditional

This block sits between one processor's load/store port and a shared memory interface and gives that processor an atomic read-modify-write primitive. A load-linked reads memory the same way an ordinary load does and arms a reservation on the word it touched. A later store-conditional to that word writes memory only while the reservation is still armed, and it returns a one-bit outcome to the destination register in place of the value that was stored.

The block observes an address stream that reports the accesses made by every other agent on the memory. Any such access to the reserved word disarms the reservation. A local ordinary store to that word, such as the release of a lock, also disarms it. A clear input lets the surrounding logic drop the reservation on a context switch or an exception. Every request is handed to memory in the cycle it arrives. The register write-back result of a load, a load-linked or a store-conditional appears exactly one cycle later.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked (req_op = 2'b10) issues a memory read of req_addr. One cycle later it returns the read word on rsp_data, tagged with req_rd, exactly as an ordinary load (req_op = 2'b00) does.
- R2: A store-conditional (req_op = 2'b11) to the reserved word, with nothing in between that disarms the reservation, writes req_wdata to memory and returns 1.
- R3: A store-conditional with no armed reservation, or to a word other than the reserved one, produces no memory access and returns 0. The stored word keeps its old value.
- R4: A store-conditional always produces a response one cycle later, with rsp_rd equal to its req_rd and rsp_data equal to exactly 0 or 1. All upper bits are zero, so the source value does not come back.
- R5: An observed access (snp_valid) to any byte of the reserved word disarms the reservation, because addresses are compared at word granularity with bits [1:0] ignored. An observed access to a different word leaves it armed.
- R6: A local ordinary store (req_op = 2'b01) to the reserved word, such as a release writing zero, disarms the reservation.
- R7: Every store-conditional disarms the reservation, whether it succeeds or fails, so a second one without a new load-linked fails.
- R8: A new load-linked replaces the reservation, so only its address can succeed afterwards.
- R9: Asserting rsv_clear disarms the reservation. It also takes priority over a load-linked in the same cycle.
- R10: In the same cycle, an observed access to the reserved word makes a store-conditional fail. An observed access to a load-linked's own word prevents that load-linked from arming.
- R11: rsp_valid is low after reset. It rises exactly one cycle after every load, load-linked or store-conditional, and never after an ordinary store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_op | input | 2 | 00 load, 01 store, 10 load-linked, 11 store-conditional |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Store data |
| req_rd | input | RD_W | Destination register index |
| mem_valid | output | 1 | Memory access issued |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, same cycle |
| snp_valid | input | 1 | Another agent accesses memory |
| snp_addr | input | ADDR_W | Address of that access |
| rsv_clear | input | 1 | Drop the reservation |
| rsp_valid | output | 1 | Write-back result present |
| rsp_rd | output | RD_W | Write-back register index |
| rsp_data | output | DATA_W | Write-back value |

## Verification
The hardest cases to reach are the same-cycle collisions. In one, an observed access lands on the reserved word in the very cycle a store-conditional arrives. In the other, it lands on a load-linked's own word. The bench reaches both by putting the snoop address and the local request in one driven cycle. It then reads the word back through an ordinary load to confirm that nothing was written. The word-granularity match is exercised by snooping another byte of the reserved word, and then the next word up.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_LL    = 2'b10,
        OP_SC    = 2'b11
    } llsc_op_e;
endpackage

// File: rtl/llsc_word_cmp.sv
module llsc_word_cmp #(
    parameter int ADDR_W  = 32,
    parameter int WORD_LSB = 2
) (
    input  logic                       en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [ADDR_W-WORD_LSB-1:0] word,
    output logic                       hit
);
    always_comb begin
        hit = en && (addr[ADDR_W-1:WORD_LSB] == word);
    end
endmodule

// File: rtl/llsc_reservation.sv
module llsc_reservation #(
    parameter int WADDR_W = 30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               kill,
    input  logic               arm,
    input  logic [WADDR_W-1:0] arm_word,
    output logic               link_q,
    output logic [WADDR_W-1:0] word_q
);
    typedef struct packed {
        logic               link;
        logic [WADDR_W-1:0] word;
    } rsv_t;

    rsv_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (kill) begin
            st_d.link = 1'b0;
        end
        if (arm) begin
            st_d.link = 1'b1;
            st_d.word = arm_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign link_q = st_q.link;
    assign word_q = st_q.word;

    assert_arm_records_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (link_q && word_q == $past(arm_word)));
endmodule

// File: rtl/llsc_resp.sv
module llsc_resp #(
    parameter int DATA_W = 32,
    parameter int RD_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [RD_W-1:0]   rd,
    input  logic [DATA_W-1:0] data,
    output logic              rsp_valid,
    output logic [RD_W-1:0]   rsp_rd,
    output logic [DATA_W-1:0] rsp_data
);
    typedef struct packed {
        logic              valid;
        logic [RD_W-1:0]   rd;
        logic [DATA_W-1:0] data;
    } rsp_t;

    rsp_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.valid = fire;
        if (fire) begin
            r_d.rd   = rd;
            r_d.data = data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid = r_q.valid;
    assign rsp_rd    = r_q.rd;
    assign rsp_data  = r_q.data;
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int RD_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [RD_W-1:0]   req_rd,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              rsv_clear,
    output logic              rsp_valid,
    output logic [RD_W-1:0]   rsp_rd,
    output logic [DATA_W-1:0] rsp_data
);
    import llsc_pkg::*;

    localparam int WORD_LSB = $clog2(DATA_W / 8);
    localparam int WADDR_W  = ADDR_W - WORD_LSB;

    llsc_op_e           op;
    logic               is_ld, is_st, is_ll, is_sc;
    logic               link_q;
    logic [WADDR_W-1:0] word_q;
    logic               snp_hit_rsv, snp_hit_req, req_hit_rsv;
    logic               sc_ok, kill, arm, fire;
    logic [DATA_W-1:0]  wb_data;

    assign op    = llsc_op_e'(req_op);
    assign is_ld = req_valid && (op == OP_LOAD);
    assign is_st = req_valid && (op == OP_STORE);
    assign is_ll = req_valid && (op == OP_LL);
    assign is_sc = req_valid && (op == OP_SC);

    // snoop versus reservation, snoop versus the local request, local request versus reservation
    llsc_word_cmp #(.ADDR_W(ADDR_W), .WORD_LSB(WORD_LSB)) u_cmp_snp_rsv (
        .en(snp_valid && link_q), .addr(snp_addr), .word(word_q), .hit(snp_hit_rsv)
    );
    llsc_word_cmp #(.ADDR_W(ADDR_W), .WORD_LSB(WORD_LSB)) u_cmp_snp_req (
        .en(snp_valid), .addr(snp_addr), .word(req_addr[ADDR_W-1:WORD_LSB]), .hit(snp_hit_req)
    );
    llsc_word_cmp #(.ADDR_W(ADDR_W), .WORD_LSB(WORD_LSB)) u_cmp_req_rsv (
        .en(link_q), .addr(req_addr), .word(word_q), .hit(req_hit_rsv)
    );

    always_comb begin
        sc_ok = is_sc && req_hit_rsv && !snp_hit_rsv && !rsv_clear;
        kill  = rsv_clear || snp_hit_rsv || is_sc || (is_st && req_hit_rsv);
        arm   = is_ll && !rsv_clear && !snp_hit_req;
        fire  = is_ld || is_ll || is_sc;

        mem_valid = is_ld || is_st || is_ll || sc_ok;
        mem_we    = is_st || sc_ok;
        mem_addr  = req_addr;
        mem_wdata = req_wdata;

        wb_data = mem_rdata;
        if (is_sc) begin
            wb_data = '0;
            wb_data[0] = sc_ok;
        end
    end

    llsc_reservation #(.WADDR_W(WADDR_W)) u_rsv (
        .clk(clk), .rst_n(rst_n), .kill(kill), .arm(arm),
        .arm_word(req_addr[ADDR_W-1:WORD_LSB]), .link_q(link_q), .word_q(word_q)
    );

    llsc_resp #(.DATA_W(DATA_W), .RD_W(RD_W)) u_resp (
        .clk(clk), .rst_n(rst_n), .fire(fire), .rd(req_rd), .data(wb_data),
        .rsp_valid(rsp_valid), .rsp_rd(rsp_rd), .rsp_data(rsp_data)
    );

    assert_sc_write_needs_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sc && mem_we) |-> link_q);
    assert_sc_result_binary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        is_sc |=> (rsp_valid && rsp_data[DATA_W-1:1] == '0));
    assert_sc_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_sc |=> !link_q);
    assert_clear_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsv_clear |=> !link_q);
    assert_collision_fails_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_sc && snp_hit_rsv) |-> !mem_valid);
    assert_resp_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && op != OP_STORE) |=> rsp_valid);
    assert_store_no_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && op != OP_STORE) |=> !rsp_valid);
endmodule

// File: tb/llsc_monitor_tb.sv
module llsc_monitor_tb;
    localparam int AW = 32, DW = 32, RW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [RW-1:0] req_rd = '0;
    logic          mem_valid, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic          snp_valid = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic          rsv_clear = 1'b0;
    logic          rsp_valid;
    logic [RW-1:0] rsp_rd;
    logic [DW-1:0] rsp_data;

    always #10 clk = ~clk;

    llsc_monitor u_dut (.*);

    logic [DW-1:0] mem [16];
    assign mem_rdata = mem[mem_addr[5:2]];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= 32'(i * 16 + 1);
        end else if (mem_valid && mem_we) begin
            mem[mem_addr[5:2]] <= mem_wdata;
        end
    end

    int total = 0, bad = 0;
    logic [DW-1:0] shadow [16];
    logic          m_link = 1'b0;
    logic [29:0]   m_word = '0;
    logic [RW-1:0] q_rd [$];
    logic [DW-1:0] q_data [$];
    string         q_tag [$];

    task automatic do_op(input logic v, input logic [1:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] wd, input logic [RW-1:0] rd,
                         input logic sv, input logic [AW-1:0] sa, input logic clr,
                         input string tag);
        logic ok, shit, qhit;
        shit = sv && m_link && (sa[AW-1:2] == m_word);
        qhit = m_link && (a[AW-1:2] == m_word);
        ok   = v && op == 2'b11 && qhit && !shit && !clr;
        if (v && op == 2'b00 || v && op == 2'b10) begin
            q_rd.push_back(rd); q_data.push_back(shadow[a[5:2]]); q_tag.push_back(tag);
        end
        if (v && op == 2'b11) begin
            q_rd.push_back(rd); q_data.push_back({31'd0, ok}); q_tag.push_back(tag);
        end
        if (v && op == 2'b01 || ok) shadow[a[5:2]] = wd;
        if (clr || shit || (v && op == 2'b11) || (v && op == 2'b01 && qhit)) m_link = 1'b0;
        if (v && op == 2'b10 && !clr && !(sv && sa[AW-1:2] == a[AW-1:2])) begin
            m_link = 1'b1; m_word = a[AW-1:2];
        end
        req_valid = v; req_op = op; req_addr = a; req_wdata = wd; req_rd = rd;
        snp_valid = sv; snp_addr = sa; rsv_clear = clr;
        @(negedge clk);
        req_valid = 1'b0; snp_valid = 1'b0; rsv_clear = 1'b0;
    endtask

    task automatic ld(input logic [AW-1:0] a, input string tag);
        do_op(1, 2'b00, a, 0, 5'd7, 0, 0, 0, tag);
    endtask
    task automatic ll(input logic [AW-1:0] a, input string tag);
        do_op(1, 2'b10, a, 0, 5'd3, 0, 0, 0, tag);
    endtask
    task automatic sc(input logic [AW-1:0] a, input logic [DW-1:0] wd, input string tag);
        do_op(1, 2'b11, a, wd, 5'd9, 0, 0, 0, tag);
    endtask
    task automatic snoop(input logic [AW-1:0] a, input string tag);
        do_op(0, 2'b00, 0, 0, 0, 1, a, 0, tag);
    endtask

    // monitor: compare each produced result with the front of the scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            total++;
            if (q_rd.size() == 0) begin
                bad++;
                $display("FAIL R11 unexpected response actual rd=%0d data=%h expected none", rsp_rd, rsp_data);
            end else begin
                if (rsp_rd !== q_rd[0] || rsp_data !== q_data[0]) begin
                    bad++;
                    $display("FAIL %s actual rd=%0d data=%h expected rd=%0d data=%h",
                             q_tag[0], rsp_rd, rsp_data, q_rd[0], q_data[0]);
                end
                void'(q_rd.pop_front()); void'(q_data.pop_front()); void'(q_tag.pop_front());
            end
        end
    end

    logic done = 1'b0;
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual hung expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) shadow[i] = 32'(i * 16 + 1);
        repeat (3) @(negedge clk);
        total++;
        if (rsp_valid !== 1'b0) begin
            bad++; $display("FAIL R11 reset actual rsp_valid=%b expected 0", rsp_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        sc(32'h10, 32'h55, "R3 sc without reservation");
        ld(32'h10, "R3 word unchanged");
        ll(32'h10, "R1 ll data");
        sc(32'h10, 32'hAA, "R2 R4 sc succeeds");
        ld(32'h10, "R2 written value");
        sc(32'h10, 32'hBB, "R7 second sc fails");
        ld(32'h10, "R7 word unchanged");
        ll(32'h20, "R1 ll data");
        snoop(32'h23, "R5");
        sc(32'h20, 32'h77, "R5 same-word snoop kills");
        ll(32'h20, "R1 ll data");
        snoop(32'h24, "R5");
        sc(32'h20, 32'h78, "R5 other-word snoop keeps");
        ld(32'h20, "R5 written value");
        ll(32'h30, "R1 ll data");
        do_op(1, 2'b01, 32'h30, 32'h0, 0, 0, 0, 0, "R6");
        sc(32'h30, 32'h5, "R6 release store kills");
        ll(32'h30, "R8 first ll");
        ll(32'h34, "R8 second ll");
        sc(32'h30, 32'h6, "R8 old address fails");
        ll(32'h30, "R8 ll");
        ll(32'h34, "R8 ll");
        sc(32'h34, 32'h66, "R8 new address succeeds");
        ll(32'h38, "R9 ll");
        do_op(0, 2'b00, 0, 0, 0, 0, 0, 1, "R9");
        sc(32'h38, 32'h9, "R9 clear kills");
        do_op(1, 2'b10, 32'h38, 0, 5'd3, 0, 0, 1, "R9 ll with clear");
        sc(32'h38, 32'h9, "R9 clear beats ll");
        ll(32'h3C, "R10 ll");
        do_op(1, 2'b11, 32'h3C, 32'hEE, 5'd9, 1, 32'h3C, 0, "R10 sc with colliding snoop");
        ld(32'h3C, "R10 word unchanged");
        do_op(1, 2'b10, 32'h08, 0, 5'd3, 1, 32'h09, 0, "R10 ll with colliding snoop");
        sc(32'h08, 32'hCC, "R10 ll did not arm");
        ld(32'h08, "R10 word unchanged");
        ll(32'h0C, "R1 ll");
        ld(32'h0C, "R1 plain load");
        sc(32'h0C, 32'hDD, "R2 sc after local load");
        ld(32'h34, "R8 written value");
        repeat (3) @(negedge clk);
        total++;
        if (q_rd.size() != 0) begin
            bad++; $display("FAIL R11 missing responses actual pending=%0d expected 0", q_rd.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule